// File: doc/BRIEF.md
# Asynchronous SRAM cycle controller

This block sits between a synchronous request port and an external 4096 x 1 static RAM that has no clock of its own. A single request carries a direction flag, a 12-bit word address and one bit of write data. The controller turns it into a correctly timed sequence on the memory pins: a 12-bit address bus, a separate data-to-memory bit, a data-from-memory bit, and active-low select and write strobes. When the access is over it returns the read bit, together with a single-cycle completion pulse.

All memory timing limits are parameters expressed in nanoseconds, and the clock period is one more parameter. At elaboration the block turns each limit into a whole number of clock cycles by rounding up, and no count is ever allowed below one. A write runs in three phases: select with the address applied, write-strobe low, then a hold phase with the strobe released. The phase lengths are chosen so that every write limit is met at the same time, and so that the whole write lasts at least one full memory cycle. A read keeps the chip selected with the write strobe high for the full access time, then captures the data.

Top module: `sramc_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, mem_cs_n and mem_we_n are both 1 and done is 0.
- R2: A read (req_wr=0) holds mem_cs_n low and mem_we_n high for ceil(135 ns / clock period) cycles after the accepting edge. On the last of those edges it captures mem_dout into rdata and raises done, and done then stays high for exactly one cycle.
- R3: During a write, mem_cs_n is low for at least 25 ns and the address is stable for at least 10 ns before mem_we_n falls, and mem_we_n never goes low while mem_cs_n is high.
- R4: The mem_we_n low pulse lasts at least 50 ns. mem_din is stable at least 35 ns before mem_we_n rises. mem_cs_n has been low at least 85 ns, and the address valid at least 80 ns, when mem_we_n rises.
- R5: mem_addr changes only while mem_we_n is high. mem_addr and mem_din stay unchanged for at least 5 ns after mem_we_n rises.
- R6: A write completes (done high) max(ceil(135/T), S+P+H) cycles after the accepting edge. Here S = ceil(25/T), P = ceil(max(50, 35, 85-S*T, 80-S*T)/T) and H = ceil(5/T), with T the clock period in ns.
- R7: A request is accepted only while idle. Strobes of req that arrive while an access is in progress do not change the memory pins and do not cause any write.
- R8: Data written to any address, including 0x000 and 0xFFF, is returned by a later read of that address until that address is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe, sampled only while idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Word address |
| req_wdata | input | 1 | Write data bit |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 1 | Read data, valid on the done cycle |
| mem_addr | output | 12 | Address to the memory |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_din | output | 1 | Data bit to the memory |
| mem_dout | input | 1 | Data bit from the memory |

## Verification
The bench memory model returns the inverse of the stored bit until a full access time has passed since the last address or select change. A controller that samples even one cycle early therefore reads back wrong data. The model times every write edge in nanoseconds, so a write phase that is one cycle short, such as a pulse shortened by an off-by-one in the counter, shows up as a setup or width violation. Requests held high during a busy write, aimed at a different address, catch a controller that re-accepts mid-access: that fault moves the pins or leaves a stray bit in the array. Writes to the extreme addresses, and an overwrite followed by a read, catch stuck or truncated address bits.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_READ   = 3'd1,
    PH_WSETUP = 3'd2,
    PH_WPULSE = 3'd3,
    PH_WHOLD  = 3'd4
  } phase_e;

  // Round a nanosecond limit up to clock cycles, never below one.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramc_down_cnt.sv
module sramc_down_cnt #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            val_q <= '0;
    else if (load)         val_q <= load_val;
    else if (val_q != '0)  val_q <= val_q - 1'b1;
  end

  assign zero = (val_q == '0);
endmodule

// File: rtl/sramc_seq.sv
module sramc_seq
  import sramc_pkg::*;
#(
  parameter int CW   = 5,
  parameter int N_RD = 14,
  parameter int N_SU = 3,
  parameter int N_WP = 6,
  parameter int N_HD = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_wr,
  input  logic          cnt_zero,
  output phase_e        phase,
  output phase_e        nxt_phase,
  output logic          cnt_load,
  output logic [CW-1:0] cnt_val,
  output logic          accept,
  output logic          finish
);
  localparam logic [CW-1:0] L_RD = CW'(N_RD - 1);
  localparam logic [CW-1:0] L_SU = CW'(N_SU - 1);
  localparam logic [CW-1:0] L_WP = CW'(N_WP - 1);
  localparam logic [CW-1:0] L_HD = CW'(N_HD - 1);

  phase_e phase_q;

  always_comb begin
    nxt_phase = phase_q;
    cnt_load  = 1'b0;
    cnt_val   = '0;
    accept    = 1'b0;
    finish    = 1'b0;
    case (phase_q)
      PH_IDLE: if (req) begin
        accept    = 1'b1;
        cnt_load  = 1'b1;
        nxt_phase = req_wr ? PH_WSETUP : PH_READ;
        cnt_val   = req_wr ? L_SU : L_RD;
      end
      PH_READ: if (cnt_zero) begin
        nxt_phase = PH_IDLE;
        finish    = 1'b1;
      end
      PH_WSETUP: if (cnt_zero) begin
        nxt_phase = PH_WPULSE;
        cnt_load  = 1'b1;
        cnt_val   = L_WP;
      end
      PH_WPULSE: if (cnt_zero) begin
        nxt_phase = PH_WHOLD;
        cnt_load  = 1'b1;
        cnt_val   = L_HD;
      end
      PH_WHOLD: if (cnt_zero) begin
        nxt_phase = PH_IDLE;
        finish    = 1'b1;
      end
      default: nxt_phase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= nxt_phase;
  end

  assign phase = phase_q;
endmodule

// File: rtl/sramc_pins.sv
module sramc_pins
  import sramc_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          finish,
  input  phase_e        phase,
  input  phase_e        nxt_phase,
  input  logic [AW-1:0] req_addr,
  input  logic          req_wdata,
  input  logic          mem_dout,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_din,
  output logic          rdata,
  output logic          done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_din  <= 1'b0;
      mem_cs_n <= 1'b1;
      mem_we_n <= 1'b1;
      rdata    <= 1'b0;
      done     <= 1'b0;
    end else begin
      if (accept) begin
        mem_addr <= req_addr;
        mem_din  <= req_wdata;
      end
      mem_cs_n <= (nxt_phase == PH_IDLE);
      mem_we_n <= (nxt_phase != PH_WPULSE);
      done     <= finish;
      if (finish && phase == PH_READ) rdata <= mem_dout;
    end
  end
endmodule

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
  import sramc_pkg::*;
#(
  parameter int AW         = 12,
  parameter int CLK_NS     = 10,
  parameter int T_CYCLE_NS = 135,
  parameter int T_ASU_NS   = 10,
  parameter int T_CSWE_NS  = 25,
  parameter int T_WPW_NS   = 50,
  parameter int T_DSU_NS   = 35,
  parameter int T_CSEND_NS = 85,
  parameter int T_AEND_NS  = 80,
  parameter int T_HOLD_NS  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic          req_wdata,
  output logic          done,
  output logic          rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_din,
  input  logic          mem_dout
);
  localparam int N_RD = ns_to_cyc(T_CYCLE_NS, CLK_NS);
  localparam int N_SU = imax(ns_to_cyc(T_ASU_NS, CLK_NS), ns_to_cyc(T_CSWE_NS, CLK_NS));
  localparam int N_WP = imax(imax(ns_to_cyc(T_WPW_NS, CLK_NS), ns_to_cyc(T_DSU_NS, CLK_NS)),
                             imax(ns_to_cyc(T_CSEND_NS, CLK_NS) - N_SU,
                                  ns_to_cyc(T_AEND_NS, CLK_NS) - N_SU));
  localparam int N_HD = imax(ns_to_cyc(T_HOLD_NS, CLK_NS), N_RD - N_SU - N_WP);
  localparam int N_MX = imax(imax(N_RD, N_SU), imax(N_WP, N_HD));
  localparam int CW   = $clog2(N_MX + 1);

  phase_e        phase, nxt_phase;
  logic          cnt_load, cnt_zero, accept, finish;
  logic [CW-1:0] cnt_val;

  // Named events for the checker.
  logic busy, ev_accept;
  assign busy      = (phase != PH_IDLE);
  assign ev_accept = accept;

  sramc_seq #(
    .CW(CW), .N_RD(N_RD), .N_SU(N_SU), .N_WP(N_WP), .N_HD(N_HD)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .cnt_zero(cnt_zero),
    .phase(phase), .nxt_phase(nxt_phase), .cnt_load(cnt_load), .cnt_val(cnt_val),
    .accept(accept), .finish(finish)
  );

  sramc_down_cnt #(.CW(CW)) cnt_i (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val), .zero(cnt_zero)
  );

  sramc_pins #(.AW(AW)) pins_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .finish(finish),
    .phase(phase), .nxt_phase(nxt_phase), .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_dout(mem_dout), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_din(mem_din), .rdata(rdata), .done(done)
  );
endmodule

// File: rtl/sramc_ctrl_chk.sv
module sramc_ctrl_chk #(
  parameter int AW       = 12,
  parameter int CLK_NS   = 10,
  parameter int T_WPW_NS = 50
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          ev_accept,
  input logic          done,
  input logic [AW-1:0] mem_addr,
  input logic          mem_cs_n,
  input logic          mem_we_n,
  input logic          mem_din
);
  localparam int WP_MIN = (T_WPW_NS + CLK_NS - 1) / CLK_NS;

  int unsigned we_lo_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         we_lo_cnt <= 0;
    else if (!mem_we_n) we_lo_cnt <= we_lo_cnt + 1;
    else                we_lo_cnt <= 0;
  end

  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_cs_n && mem_we_n));

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_we_needs_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs_n);

  p_cs_leads_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(!mem_cs_n));

  p_we_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo_cnt >= WP_MIN));

  p_pins_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> ($stable(mem_addr) && $stable(mem_din)));

  p_hold_after_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |=> ($stable(mem_addr) && $stable(mem_din)));

  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mem_addr));

  p_accept_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> !busy);
endmodule

bind sramc_ctrl sramc_ctrl_chk #(
  .AW(AW), .CLK_NS(CLK_NS), .T_WPW_NS(T_WPW_NS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ev_accept(ev_accept), .done(done),
  .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_din(mem_din)
);

// File: tb/sramc_ctrl_tb_top.sv
`timescale 1ns/1ps
module sramc_ctrl_tb_top;
  localparam int AW = 12;
  localparam int TCK = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_wr = 1'b0, req_wdata = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic done, rdata, mem_cs_n, mem_we_n, mem_din;
  logic [AW-1:0] mem_addr;
  logic mem_dout;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  sramc_ctrl #(.AW(AW), .CLK_NS(TCK)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .rdata(rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_din(mem_din), .mem_dout(mem_dout)
  );

  // ---------------- behavioural memory with timing checks ----------------
  logic mem_arr [0:4095];
  bit   armed = 1'b0;
  realtime t_addr = -1000.0, t_cs = -1000.0, t_wf = -1000.0, t_wr = -1000.0, t_din = -1000.0;
  int   acc_seq = 0;
  bit   acc_ok = 1'b0;

  task automatic tfail(input string req_id, input string what, input realtime act, input realtime lim);
    n_chk++; n_bad++;
    $display("FAIL %s %s: actual %0.2f ns expected >= %0.2f ns", req_id, what, act, lim);
  endtask

  always @(mem_addr) if (armed) begin
    if (!mem_we_n) tfail("R5", "address moved with strobe low", 0.0, 1.0);
    if ($realtime - t_wr < 5.0) tfail("R5", "address hold", $realtime - t_wr, 5.0);
    t_addr = $realtime;
  end

  always @(mem_din) if (armed) begin
    if ($realtime - t_wr < 5.0) tfail("R5", "data hold", $realtime - t_wr, 5.0);
    t_din = $realtime;
  end

  always @(negedge mem_cs_n) if (armed) t_cs = $realtime;

  always @(posedge mem_cs_n) if (armed && !mem_we_n)
    tfail("R4", "select released during strobe", 0.0, 1.0);

  always @(negedge mem_we_n) if (armed) begin
    if (mem_cs_n) tfail("R3", "strobe low without select", 0.0, 1.0);
    if ($realtime - t_cs < 25.0)   tfail("R3", "select to strobe", $realtime - t_cs, 25.0);
    if ($realtime - t_addr < 10.0) tfail("R3", "address setup", $realtime - t_addr, 10.0);
    t_wf = $realtime;
  end

  always @(posedge mem_we_n) if (armed) begin
    if ($realtime - t_wf < 50.0)   tfail("R4", "strobe width", $realtime - t_wf, 50.0);
    if ($realtime - t_cs < 85.0)   tfail("R4", "select to end", $realtime - t_cs, 85.0);
    if ($realtime - t_addr < 80.0) tfail("R4", "address to end", $realtime - t_addr, 80.0);
    if ($realtime - t_din < 35.0)  tfail("R4", "data setup", $realtime - t_din, 35.0);
    mem_arr[mem_addr] = mem_din;
    t_wr = $realtime;
  end

  // Output is the inverted bit until a full access time has elapsed.
  always @(mem_addr or mem_cs_n or mem_we_n) begin
    acc_seq++;
    acc_ok = 1'b0;
    fork
      begin : acc_wait
        automatic int my = acc_seq;
        #134.5;
        if (acc_seq == my) acc_ok = 1'b1;
      end
    join_none
  end

  assign mem_dout = (acc_ok && !mem_cs_n && mem_we_n) ? mem_arr[mem_addr] : ~mem_arr[mem_addr];

  // ---------------- expected latencies, restated ----------------
  function automatic int up(input int ns);
    return (ns + TCK - 1) / TCK;
  endfunction
  function automatic int exp_rd_lat();
    return up(135);
  endfunction
  function automatic int exp_wr_lat();
    int s, p, h, need;
    s = up(25);
    need = 50;
    if (35 > need) need = 35;
    if (85 - s*TCK > need) need = 85 - s*TCK;
    if (80 - s*TCK > need) need = 80 - s*TCK;
    p = up(need);
    h = up(5);
    return (s + p + h > up(135)) ? s + p + h : up(135);
  endfunction

  task automatic chk(input bit ok, input string req_id, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req_id, what, act, expv);
    end
  endtask

  task automatic do_op(input bit wr, input logic [AW-1:0] a, input bit wd, output bit rd, output int lat);
    @(negedge clk);
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    lat = 0;
    while (!done && lat < 1000) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    rd = rdata;
    chk(mem_cs_n === 1'b1 && mem_we_n === 1'b1, "R1", "pins idle at done", {mem_cs_n, mem_we_n}, 3);
    @(posedge clk); @(negedge clk);
    chk(done === 1'b0, "R2", "done single cycle", done, 0);
  endtask

  // ---------------- vector table: {wr, addr[11:0], data} ----------------
  localparam int NV = 16;
  localparam logic [13:0] VEC [NV] = '{
    {1'b1, 12'h000, 1'b1}, {1'b1, 12'hFFF, 1'b1}, {1'b1, 12'h800, 1'b1}, {1'b1, 12'h555, 1'b1},
    {1'b0, 12'h000, 1'b1}, {1'b0, 12'hFFF, 1'b1}, {1'b0, 12'h800, 1'b1}, {1'b0, 12'h555, 1'b1},
    {1'b0, 12'hAAA, 1'b0}, {1'b1, 12'h000, 1'b0}, {1'b0, 12'h000, 1'b0}, {1'b1, 12'h7FF, 1'b1},
    {1'b0, 12'h7FF, 1'b1}, {1'b0, 12'h001, 1'b0}, {1'b0, 12'hFFE, 1'b0}, {1'b0, 12'hFFF, 1'b1}
  };

  localparam int NR = 48;
  logic [AW-1:0] r_addr [NR];
  logic          shadow [0:4095];

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit rd;
    int lat;
    for (int i = 0; i < 4096; i++) begin mem_arr[i] = 1'b0; shadow[i] = 1'b0; end

    // Reset state (R1)
    repeat (3) @(negedge clk);
    chk(mem_cs_n === 1'b1 && mem_we_n === 1'b1 && done === 1'b0, "R1", "reset pins",
        {mem_cs_n, mem_we_n, done}, 6);
    rst_n = 1'b1;
    armed = 1'b1;
    repeat (2) @(negedge clk);
    chk(mem_cs_n === 1'b1 && mem_we_n === 1'b1, "R1", "idle after reset", {mem_cs_n, mem_we_n}, 3);

    // Table walk (R2, R6, R8)
    for (int v = 0; v < NV; v++) begin
      do_op(VEC[v][13], VEC[v][12:1], VEC[v][0], rd, lat);
      if (VEC[v][13]) begin
        chk(lat == exp_wr_lat(), "R6", "write latency", lat, exp_wr_lat());
      end else begin
        chk(lat == exp_rd_lat(), "R2", "read latency", lat, exp_rd_lat());
        chk(rd == VEC[v][0], "R8", "table read data", rd, VEC[v][0]);
      end
    end
    shadow[12'h000] = 1'b0; shadow[12'hFFF] = 1'b1; shadow[12'h800] = 1'b1;
    shadow[12'h555] = 1'b1; shadow[12'h7FF] = 1'b1;

    // Requests while busy are ignored (R7)
    @(negedge clk);
    req = 1'b1; req_wr = 1'b1; req_addr = 12'h123; req_wdata = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_addr = 12'h124;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); @(negedge clk);
      chk(mem_addr == 12'h123, "R7", "pins during busy", mem_addr, 12'h123);
    end
    req = 1'b0;
    while (!done) begin @(posedge clk); @(negedge clk); end
    shadow[12'h123] = 1'b1;
    do_op(1'b0, 12'h124, 1'b0, rd, lat);
    chk(rd == 1'b0, "R7", "no stray write", rd, 0);
    do_op(1'b0, 12'h123, 1'b0, rd, lat);
    chk(rd == 1'b1, "R8", "accepted write kept", rd, 1);

    // Random write-then-read (R8)
    for (int i = 0; i < NR; i++) begin
      logic b;
      r_addr[i] = AW'($urandom_range(0, 4095));
      b = 1'($urandom_range(0, 1));
      shadow[r_addr[i]] = b;
      do_op(1'b1, r_addr[i], b, rd, lat);
    end
    for (int i = 0; i < NR; i++) begin
      do_op(1'b0, r_addr[i], 1'b0, rd, lat);
      chk(rd == shadow[r_addr[i]], "R8", "random read data", rd, shadow[r_addr[i]]);
    end

    // Reset mid-access returns pins to idle (R1)
    @(negedge clk);
    req = 1'b1; req_wr = 1'b1; req_addr = 12'h0F0; req_wdata = 1'b1;
    @(negedge clk);
    req = 1'b0;
    armed = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(mem_cs_n === 1'b1 && mem_we_n === 1'b1 && done === 1'b0, "R1", "reset mid access",
        {mem_cs_n, mem_we_n, done}, 6);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule